// File: doc/BRIEF.md
# Tracking Setpoint Controller for a Follower Rail

This block produces the digital regulation setpoint for a follower supply rail whose voltage must stay under the voltage of a master rail. The block does not generate its own soft-start ramp. Each cycle it takes a digitized sample of the master rail, scales it to the full value or to half, and optionally caps it at the follower's own target code. The master's ramp therefore sets both the rise and the fall of the follower's setpoint.

A shared enable starts the sequence. One arming cycle follows, and after it the output stage is enabled and tracking begins. When the enable drops, the follower keeps tracking the master down. It stops when the master sample reaches zero, or when a turn-off timeout counted in milliseconds runs out, whichever comes first. The timeout should be set to the master's turn-off delay plus its fall time plus 5 ms. A power-good flag watches the follower's sampled output code against a threshold and is qualified by a programmable delay. An option decides whether the setpoint may fall before power-good has ever been reached.

The configuration inputs are static. The millisecond time base comes from a parameterized divider of the clock.

Top module: `trk_ref_ctrl`

## Requirements
- R1: After reset, `ref_code_o`, `out_en_o` and `pg_o` are all 0.
- R2: While `trk_on_i` is 0, `en_i` has no effect: `out_en_o` stays 0 and `ref_code_o` stays 0.
- R3: With `trk_on_i` at 1, the first clock edge that samples `en_i` high is an arming cycle in which `out_en_o` stays 0. The next edge, if `en_i` is still high, sets `out_en_o` to 1 and loads the tracked setpoint.
- R4: While tracking, the setpoint is the master code when `ratio_full_i` is 1, and the master code shifted right by one bit (floor of half) when it is 0. It updates one clock after the master sample is taken.
- R5: When `cap_at_target_i` is 1, the setpoint is the smaller of the scaled master code and `target_code_i`. When it is 0, the scaled code passes uncapped.
- R6: When `fall_early_i` is 0 and power-good has not yet been asserted since the enable, the setpoint never decreases while the output is enabled. When `fall_early_i` is 1, the setpoint follows the master downward.
- R7: After `en_i` falls, the output stays enabled and tracking until `off_timeout_i` milliseconds have elapsed. At that point `out_en_o` and `ref_code_o` are forced to 0, even if the master has not reached zero.
- R8: During turn-off, a master sample of 0 ends turn-off on that clock edge, and `out_en_o` goes to 0.
- R9: `pg_o` asserts only after `fb_code_i >= pg_thresh_i` has held continuously, with the output enabled, for `pg_delay_i` milliseconds.
- R10: `pg_o` drops on the clock edge after `fb_code_i` falls below `pg_thresh_i`, and on the same edge that `out_en_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Shared group enable |
| trk_on_i | input | 1 | Tracking mode enable |
| ratio_full_i | input | 1 | 1: 100 % ratio, 0: 50 % ratio |
| cap_at_target_i | input | 1 | 1: cap setpoint at target code |
| fall_early_i | input | 1 | 1: allow setpoint to fall before power-good |
| master_code_i | input | CODE_W | Sampled master rail code |
| target_code_i | input | CODE_W | Follower target code |
| fb_code_i | input | CODE_W | Sampled follower output code |
| pg_thresh_i | input | CODE_W | Power-good threshold code |
| pg_delay_i | input | MS_W | Power-good qualification delay in ms |
| off_timeout_i | input | MS_W | Turn-off timeout in ms |
| ref_code_o | output | CODE_W | Regulation setpoint |
| out_en_o | output | 1 | Output stage enable |
| pg_o | output | 1 | Power-good flag |

## Verification
On every cycle the assertions check that the setpoint never exceeds the target when capping is on, and that it never falls before power-good while the fall option is off. They also check that the arming cycle leads into an enabled output, that an expired timeout disables the output, and that power-good is never high with the output off and clears after a sample below threshold. The bench's scenarios are needed to show the exact arithmetic of the ratio and cap over the full code range, the millisecond lengths of the power-good delay and the turn-off timeout, and the early end of turn-off when the master reaches zero.

// File: rtl/trk_pkg.sv
package trk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ARMED   = 3'd1,
    ST_TRACK   = 3'd2,
    ST_TURNOFF = 3'd3,
    ST_OFF     = 3'd4
  } trk_state_t;
endpackage

// File: rtl/trk_tick_gen.sv
// Millisecond strobe: one-cycle pulse every DIV clocks, restarted by clr_i.
module trk_tick_gen #(
  parameter int DIV = 200000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = ~clr_i;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      assign tick_o = (cnt_q == CW'(DIV - 1)) && !clr_i;
      always_ff @(posedge clk) begin
        if (rst || clr_i)  cnt_q <= '0;
        else if (tick_o)   cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
      end

      a_tick_single: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/trk_ref_calc.sv
// Scales the master sample and applies the optional cap (R4, R5).
module trk_ref_calc #(
  parameter int CODE_W = 10
) (
  input  logic [CODE_W-1:0] master_i,
  input  logic [CODE_W-1:0] target_i,
  input  logic              full_i,
  input  logic              cap_i,
  output logic [CODE_W-1:0] ref_o
);
  logic [CODE_W-1:0] scaled;
  always_comb begin
    scaled = full_i ? master_i : (master_i >> 1);
    ref_o  = (cap_i && (scaled > target_i)) ? target_i : scaled;
  end
endmodule

// File: rtl/trk_pg_filter.sv
// Power-good qualification: condition must hold for delay_i ms (R9, R10).
module trk_pg_filter #(
  parameter int MS_W = 8,
  parameter int DIV  = 200000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            above_i,
  input  logic [MS_W-1:0] delay_i,
  output logic            pg_o
);
  logic            tick;
  logic [MS_W-1:0] ms_q;
  logic            pg_q;

  trk_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst(rst), .clr_i(!above_i), .tick_o(tick)
  );

  always_ff @(posedge clk) begin
    if (rst || !above_i) begin
      ms_q <= '0;
      pg_q <= 1'b0;
    end else begin
      if (tick && (ms_q != {MS_W{1'b1}})) ms_q <= ms_q + 1'b1;
      pg_q <= (ms_q >= delay_i);
    end
  end
  assign pg_o = pg_q;

  a_r10_drop_below: assert property (@(posedge clk) disable iff (rst)
    !above_i |=> !pg_o);
endmodule

// File: rtl/trk_ref_ctrl.sv
module trk_ref_ctrl #(
  parameter int CODE_W   = 10,
  parameter int MS_W     = 8,
  parameter int TICK_DIV = 200000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              trk_on_i,
  input  logic              ratio_full_i,
  input  logic              cap_at_target_i,
  input  logic              fall_early_i,
  input  logic [CODE_W-1:0] master_code_i,
  input  logic [CODE_W-1:0] target_code_i,
  input  logic [CODE_W-1:0] fb_code_i,
  input  logic [CODE_W-1:0] pg_thresh_i,
  input  logic [MS_W-1:0]   pg_delay_i,
  input  logic [MS_W-1:0]   off_timeout_i,
  output logic [CODE_W-1:0] ref_code_o,
  output logic              out_en_o,
  output logic              pg_o
);
  import trk_pkg::*;

  trk_state_t        state_q, state_d;
  logic [CODE_W-1:0] calc_ref, ref_q, ref_d;
  logic              out_en_q, out_en_d;
  logic [MS_W-1:0]   off_cnt_q;
  logic              off_tick;
  logic              pg_seen_q;
  logic              hold;

  trk_ref_calc #(.CODE_W(CODE_W)) u_calc (
    .master_i(master_code_i), .target_i(target_code_i),
    .full_i(ratio_full_i), .cap_i(cap_at_target_i), .ref_o(calc_ref)
  );

  trk_tick_gen #(.DIV(TICK_DIV)) u_off_tick (
    .clk(clk), .rst(rst), .clr_i(state_q != ST_TURNOFF), .tick_o(off_tick)
  );

  trk_pg_filter #(.MS_W(MS_W), .DIV(TICK_DIV)) u_pg (
    .clk(clk), .rst(rst),
    .above_i(out_en_d && (fb_code_i >= pg_thresh_i)),
    .delay_i(pg_delay_i), .pg_o(pg_o)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (en_i && trk_on_i) state_d = ST_ARMED;
      ST_ARMED:   state_d = en_i ? ST_TRACK : ST_IDLE;
      ST_TRACK:   if (!en_i) state_d = ST_TURNOFF;
      ST_TURNOFF: if ((master_code_i == '0) || (off_cnt_q >= off_timeout_i))
                    state_d = ST_OFF;
      ST_OFF:     state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    out_en_d = (state_d == ST_TRACK) || (state_d == ST_TURNOFF);
    hold     = !pg_seen_q && !fall_early_i && (calc_ref < ref_q);
    if (!out_en_d) ref_d = '0;
    else           ref_d = hold ? ref_q : calc_ref;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ref_q     <= '0;
      out_en_q  <= 1'b0;
      off_cnt_q <= '0;
      pg_seen_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      ref_q    <= ref_d;
      out_en_q <= out_en_d;
      if (state_q != ST_TURNOFF)
        off_cnt_q <= '0;
      else if (off_tick && (off_cnt_q != {MS_W{1'b1}}))
        off_cnt_q <= off_cnt_q + 1'b1;
      if (state_q == ST_IDLE) pg_seen_q <= 1'b0;
      else if (pg_o)          pg_seen_q <= 1'b1;
    end
  end

  assign ref_code_o = ref_q;
  assign out_en_o   = out_en_q;

  a_r3_arm_then_track: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ARMED && en_i) |=> out_en_q);
  a_r5_ref_capped: assert property (@(posedge clk) disable iff (rst)
    cap_at_target_i |=> (ref_q <= $past(target_code_i)));
  a_r6_no_drop_before_pg: assert property (@(posedge clk) disable iff (rst)
    (out_en_q && !pg_seen_q && !fall_early_i) |=>
      (!out_en_q || (ref_q >= $past(ref_q))));
  a_r7_timeout_off: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TURNOFF && off_cnt_q >= off_timeout_i) |=> !out_en_q);
  a_r10_pg_needs_output: assert property (@(posedge clk) disable iff (rst)
    pg_o |-> out_en_q);
endmodule

// File: tb/trk_ref_ctrl_tb.sv
module trk_ref_ctrl_tb;
  localparam int CW  = 6;
  localparam int MW  = 4;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 0, trk_on = 0, ratio_full = 0, cap = 0, fall_early = 0;
  logic [CW-1:0] master = '0, target = 6'd20, fb = '0, thr = 6'd30;
  logic [MW-1:0] pg_dly = 4'd2, off_to = 4'd3;
  logic [CW-1:0] ref_code;
  logic out_en, pg;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trk_ref_ctrl #(.CODE_W(CW), .MS_W(MW), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .en_i(en), .trk_on_i(trk_on),
    .ratio_full_i(ratio_full), .cap_at_target_i(cap),
    .fall_early_i(fall_early), .master_code_i(master),
    .target_code_i(target), .fb_code_i(fb), .pg_thresh_i(thr),
    .pg_delay_i(pg_dly), .off_timeout_i(off_to),
    .ref_code_o(ref_code), .out_en_o(out_en), .pg_o(pg)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    edges(3);
    @(negedge clk) rst = 0;
    edges(1);
    chk("R1 ref", ref_code, 0);
    chk("R1 out_en", out_en, 0);
    chk("R1 pg", pg, 0);

    // R2: tracking mode off, enable ignored
    @(negedge clk) begin en = 1; master = 6'd40; end
    edges(6);
    chk("R2 out_en", out_en, 0);
    chk("R2 ref", ref_code, 0);
    @(negedge clk) en = 0;
    edges(2);

    // R3: arming cycle then tracking
    @(negedge clk) begin trk_on = 1; fall_early = 1; ratio_full = 1; master = 6'd12; en = 1; end
    edges(1);
    chk("R3 armed out_en", out_en, 0);
    edges(1);
    chk("R3 track out_en", out_en, 1);
    chk("R3 ref", ref_code, 12);

    // R4 / R5: sweep all master codes under every ratio/cap setting
    for (int c = 0; c < 4; c++) begin
      for (int m = 0; m < 64; m++) begin
        int e;
        @(negedge clk) begin ratio_full = c[0]; cap = c[1]; master = m[CW-1:0]; end
        edges(1);
        e = c[0] ? m : m / 2;
        if (c[1] && e > 20) e = 20;
        chk(c[1] ? "R5 capped" : "R4 ratio", ref_code, e);
      end
    end

    // R6: no fall before power-good unless option set
    @(negedge clk) begin fall_early = 0; ratio_full = 0; cap = 0; master = 6'd40; end
    edges(1);
    chk("R6 rise", ref_code, 20);
    @(negedge clk) master = 6'd10;
    edges(2);
    chk("R6 held", ref_code, 20);
    @(negedge clk) fall_early = 1;
    edges(1);
    chk("R6 falls with option", ref_code, 5);

    // R9: power-good delay
    @(negedge clk) begin ratio_full = 1; cap = 1; master = 6'd40; fb = 6'd40; end
    edges(5);
    chk("R9 pg early", pg, 0);
    edges(7);
    chk("R9 pg after delay", pg, 1);
    // R10: drop below threshold
    @(negedge clk) fb = 6'd10;
    edges(1);
    chk("R10 pg drop", pg, 0);
    @(negedge clk) fb = 6'd40;
    edges(12);
    chk("R9 pg again", pg, 1);

    // R7: timeout forces off while master stays high
    @(negedge clk) en = 0;
    edges(10);
    chk("R7 still on", out_en, 1);
    chk("R7 still tracking", ref_code, 20);
    edges(6);
    chk("R7 forced off", out_en, 0);
    chk("R7 ref zero", ref_code, 0);
    chk("R10 pg off with output", pg, 0);

    // R8: master reaching zero ends turn-off early
    @(negedge clk) en = 1;
    edges(3);
    chk("R8 tracking", out_en, 1);
    @(negedge clk) en = 0;
    edges(2);
    chk("R8 in turn-off", out_en, 1);
    @(negedge clk) master = '0;
    edges(1);
    chk("R8 early off", out_en, 0);
    chk("R8 ref zero", ref_code, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule